// File: doc/BRIEF.md
# Duplex Lockstep Checker with Escalating Recovery

This block sits beside a pair of processors that run the same program in lockstep. Every cycle it compares the two processors' output buses and their valid strobes. It also merges in fault flags raised by the other interface blocks of the module. All of these become a single fault decision, and it records which kind of fault won.

The first fault starts a recovery. The block asks for a rollback. If nobody acknowledges the rollback within a fixed number of cycles, it asks for a full restart instead. Once recovery is acknowledged, a programmable watch window opens.

A fault that arrives inside the watch window is treated as a repeat. Depending on a mode input, a repeat either stops the whole module or drops to a single trusted processor:

- **Stop:** both processors are halted and the module outputs are disabled.
- **Degrade:** processor A stays in service and processor B is held.

In the degraded state, comparison faults are ignored. A flag from another block still stops the module. A fault that arrives after the window closes is handled as a fresh first fault.

Top module: `dual_lockstep_guard`

## Requirements
- R1: After reset the block is in state RUN (code 0): out_en=1, every halt and request output is 0, fault_src=0 and fault_flags=0.
- R2: A fault is raised when both valid strobes are 1 and the data buses differ. Equal data, or both strobes 0 with any data, raises nothing. A data fault is recorded as fault_src=1.
- R3: A valid strobe that is 1 on one processor and 0 on the other is a fault recorded as fault_src=2.
- R4: Any bit set in blk_fault is a fault recorded as fault_src=3. The blk_fault vector is captured in fault_flags; a comparison-only fault captures 0.
- R5: When faults coincide, an external flag takes priority over a data mismatch, which takes priority over a strobe skew.
- R6: A fault in RUN, presented in one cycle, gives state ROLLBACK (code 1) two clocks later. rollback_req is 1 in that state and stays 1 until rollback_ack is seen.
- R7: With no acknowledge, ROLLBACK lasts exactly ACK_TIMEOUT cycles and then moves to RESTART (code 2). restart_req is 1 until restart_ack is seen.
- R8: With degrade_en=0, a fault presented in any of the window_len cycles beginning with the acknowledge cycle gives HALT (code 5): halt_cpu_a=halt_cpu_b=1 and out_en=0.
- R9: HALT persists through any input activity until rst_n is asserted.
- R10: With degrade_en=1, a repeat fault gives SIMPLEX (code 4): halt_cpu_b=1, simplex_active=1, halt_cpu_a=0 and out_en=1.
- R11: In SIMPLEX, data and strobe faults are masked. A blk_fault flag gives HALT with fault_src=3.
- R12: A fault presented window_len or more cycles after the acknowledge cycle is a new first fault and gives ROLLBACK. With window_len=0 there is no watch window.
- R13: Faults arriving during ROLLBACK or RESTART are ignored and leave fault_src and fault_flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_a_valid | input | 1 | Processor A output strobe |
| cpu_a_data | input | DATA_W | Processor A output bus |
| cpu_b_valid | input | 1 | Processor B output strobe |
| cpu_b_data | input | DATA_W | Processor B output bus |
| blk_fault | input | NFLAG | Fault flags from the other interface blocks |
| degrade_en | input | 1 | Repeat-fault response: 0 stop, 1 continue on processor A |
| window_len | input | WIN_W | Watch window length in cycles |
| rollback_ack | input | 1 | Rollback finished |
| restart_ack | input | 1 | Restart finished |
| rollback_req | output | 1 | Rollback requested |
| restart_req | output | 1 | Restart requested |
| halt_cpu_a | output | 1 | Hold processor A |
| halt_cpu_b | output | 1 | Hold processor B |
| out_en | output | 1 | Module output enable |
| simplex_active | output | 1 | Running on processor A alone |
| rec_state | output | 3 | Recovery state code |
| fault_src | output | 2 | Source of the last accepted fault |
| fault_flags | output | NFLAG | blk_fault captured at the last accepted fault |

## Verification
The hardest situation to reach from the ports is the exact edge of the watch window. There, the same fault must become a halt, a degrade or a fresh rollback depending on how many cycles it trails the acknowledge.

The bench sweeps every window length from 0 to 4 against every fault offset from 0 to 5, in both repeat modes and for all three fault kinds. It computes the expected state from the offset-versus-length rule.

Separate directed sequences cover the remaining corners:
- walking the rollback timeout into a restart;
- injecting faults during recovery;
- exercising the masking in the single-processor state.

// File: rtl/dlg_pkg.sv
package dlg_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_ROLLBACK = 3'd1,
    ST_RESTART  = 3'd2,
    ST_WATCH    = 3'd3,
    ST_SIMPLEX  = 3'd4,
    ST_HALT     = 3'd5
  } rec_state_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DATA = 2'd1,
    SRC_SKEW = 2'd2,
    SRC_EXT  = 2'd3
  } fault_src_t;

endpackage

// File: rtl/dlg_rst_sync.sv
module dlg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/dlg_lockstep_cmp.sv
module dlg_lockstep_cmp #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              a_valid,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  input  logic [DATA_W-1:0] b_data,
  output logic              data_mis,
  output logic              skew_mis
);

  localparam int NLANE = (DATA_W + LANE_W - 1) / LANE_W;
  localparam int PAD_W = NLANE * LANE_W;

  logic [PAD_W-1:0] a_pad;
  logic [PAD_W-1:0] b_pad;
  logic [NLANE-1:0] lane_neq;

  assign a_pad = PAD_W'(a_data);
  assign b_pad = PAD_W'(b_data);

  // One inequality term per lane keeps the reduction tree shallow.
  genvar g;
  generate
    for (g = 0; g < NLANE; g++) begin : g_lane
      assign lane_neq[g] = |(a_pad[g*LANE_W +: LANE_W] ^ b_pad[g*LANE_W +: LANE_W]);
    end
  endgenerate

  assign data_mis = a_valid & b_valid & (|lane_neq);
  assign skew_mis = a_valid ^ b_valid;

endmodule

// File: rtl/dlg_fault_gather.sv
module dlg_fault_gather
  import dlg_pkg::*;
#(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_mis,
  input  logic             skew_mis,
  input  logic [NFLAG-1:0] ext_flags,
  output logic             cmp_fault_q,
  output logic             ext_fault_q,
  output fault_src_t       src_q,
  output logic [NFLAG-1:0] flags_q
);

  logic       cmp_fault_d;
  logic       ext_fault_d;
  fault_src_t src_d;

  always_comb begin
    ext_fault_d = |ext_flags;
    cmp_fault_d = data_mis | skew_mis;
    if (ext_fault_d)   src_d = SRC_EXT;
    else if (data_mis) src_d = SRC_DATA;
    else if (skew_mis) src_d = SRC_SKEW;
    else               src_d = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_fault_q <= 1'b0;
      ext_fault_q <= 1'b0;
      src_q       <= SRC_NONE;
      flags_q     <= '0;
    end else begin
      cmp_fault_q <= cmp_fault_d;
      ext_fault_q <= ext_fault_d;
      src_q       <= src_d;
      flags_q     <= ext_flags;
    end
  end

  AST_EXT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_flags) |=> (src_q == SRC_EXT && ext_fault_q)); // R5
  AST_DATA_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (data_mis && !(|ext_flags)) |=> (src_q == SRC_DATA && cmp_fault_q)); // R2

endmodule

// File: rtl/dlg_recovery_fsm.sv
module dlg_recovery_fsm
  import dlg_pkg::*;
#(
  parameter int NFLAG       = 4,
  parameter int WIN_W       = 8,
  parameter int ACK_TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_fault,
  input  logic             ext_fault,
  input  fault_src_t       src_in,
  input  logic [NFLAG-1:0] flags_in,
  input  logic             degrade_en,
  input  logic [WIN_W-1:0] window_len,
  input  logic             rb_ack,
  input  logic             rs_ack,
  output rec_state_t       state_q,
  output fault_src_t       rec_src_q,
  output logic [NFLAG-1:0] rec_flags_q
);

  localparam int TMR_W = (ACK_TIMEOUT > 1) ? $clog2(ACK_TIMEOUT) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(ACK_TIMEOUT - 1);
  localparam logic [WIN_W-1:0] WIN_ONE  = WIN_W'(1);

  rec_state_t       state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             rec_en;
  logic             any_fault;

  assign any_fault = cmp_fault | ext_fault;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    win_d   = win_q;
    rec_en  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (any_fault) begin
          state_d = ST_ROLLBACK;
          tmr_d   = '0;
          rec_en  = 1'b1;
        end
      end
      ST_ROLLBACK: begin
        if (rb_ack) begin
          if (window_len == '0) state_d = ST_RUN;
          else begin
            state_d = ST_WATCH;
            win_d   = window_len;
          end
        end else if (tmr_q == TMR_LAST) begin
          state_d = ST_RESTART;
        end else begin
          tmr_d = tmr_q + TMR_W'(1);
        end
      end
      ST_RESTART: begin
        if (rs_ack) begin
          if (window_len == '0) state_d = ST_RUN;
          else begin
            state_d = ST_WATCH;
            win_d   = window_len;
          end
        end
      end
      ST_WATCH: begin
        if (any_fault) begin
          state_d = degrade_en ? ST_SIMPLEX : ST_HALT;
          rec_en  = 1'b1;
        end else if (win_q == WIN_ONE) begin
          state_d = ST_RUN;
        end else begin
          win_d = win_q - WIN_ONE;
        end
      end
      ST_SIMPLEX: begin
        if (ext_fault) begin
          state_d = ST_HALT;
          rec_en  = 1'b1;
        end
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      tmr_q       <= '0;
      win_q       <= '0;
      rec_src_q   <= SRC_NONE;
      rec_flags_q <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      win_q   <= win_d;
      if (rec_en) begin
        rec_src_q   <= src_in;
        rec_flags_q <= flags_in;
      end
    end
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT) |=> (state_q == ST_HALT)); // R9
  AST_REPEAT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WATCH && any_fault && !degrade_en) |=> (state_q == ST_HALT)); // R8
  AST_REPEAT_DEGRADE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WATCH && any_fault && degrade_en) |=> (state_q == ST_SIMPLEX)); // R10
  AST_SIMPLEX_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SIMPLEX && !ext_fault) |=> (state_q == ST_SIMPLEX && $stable(rec_src_q))); // R11
  AST_RB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROLLBACK && !rb_ack && tmr_q != TMR_LAST) |=> (state_q == ST_ROLLBACK)); // R6
  AST_RB_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROLLBACK && !rb_ack && tmr_q == TMR_LAST) |=> (state_q == ST_RESTART)); // R7
  AST_WATCH_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WATCH) |-> (win_q != '0)); // R12
  AST_RECOVERY_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROLLBACK || state_q == ST_RESTART) |=> $stable(rec_src_q)); // R13

endmodule

// File: rtl/dual_lockstep_guard.sv
module dual_lockstep_guard
  import dlg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LANE_W      = 8,
  parameter int NFLAG       = 4,
  parameter int WIN_W       = 8,
  parameter int ACK_TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_a_valid,
  input  logic [DATA_W-1:0] cpu_a_data,
  input  logic              cpu_b_valid,
  input  logic [DATA_W-1:0] cpu_b_data,
  input  logic [NFLAG-1:0]  blk_fault,
  input  logic              degrade_en,
  input  logic [WIN_W-1:0]  window_len,
  input  logic              rollback_ack,
  input  logic              restart_ack,
  output logic              rollback_req,
  output logic              restart_req,
  output logic              halt_cpu_a,
  output logic              halt_cpu_b,
  output logic              out_en,
  output logic              simplex_active,
  output logic [2:0]        rec_state,
  output logic [1:0]        fault_src,
  output logic [NFLAG-1:0]  fault_flags
);

  logic             rst_sync_n;
  logic             data_mis;
  logic             skew_mis;
  logic             cmp_fault_q;
  logic             ext_fault_q;
  fault_src_t       src_q;
  logic [NFLAG-1:0] flags_q;
  rec_state_t       state_q;
  fault_src_t       rec_src_q;

  dlg_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dlg_lockstep_cmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
    .a_valid  (cpu_a_valid),
    .a_data   (cpu_a_data),
    .b_valid  (cpu_b_valid),
    .b_data   (cpu_b_data),
    .data_mis (data_mis),
    .skew_mis (skew_mis)
  );

  dlg_fault_gather #(.NFLAG(NFLAG)) u_gather (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .data_mis    (data_mis),
    .skew_mis    (skew_mis),
    .ext_flags   (blk_fault),
    .cmp_fault_q (cmp_fault_q),
    .ext_fault_q (ext_fault_q),
    .src_q       (src_q),
    .flags_q     (flags_q)
  );

  dlg_recovery_fsm #(.NFLAG(NFLAG), .WIN_W(WIN_W), .ACK_TIMEOUT(ACK_TIMEOUT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cmp_fault   (cmp_fault_q),
    .ext_fault   (ext_fault_q),
    .src_in      (src_q),
    .flags_in    (flags_q),
    .degrade_en  (degrade_en),
    .window_len  (window_len),
    .rb_ack      (rollback_ack),
    .rs_ack      (restart_ack),
    .state_q     (state_q),
    .rec_src_q   (rec_src_q),
    .rec_flags_q (fault_flags)
  );

  assign rollback_req   = (state_q == ST_ROLLBACK);
  assign restart_req    = (state_q == ST_RESTART);
  assign halt_cpu_a     = (state_q == ST_HALT);
  assign halt_cpu_b     = (state_q == ST_HALT) | (state_q == ST_SIMPLEX);
  assign out_en         = (state_q != ST_HALT);
  assign simplex_active = (state_q == ST_SIMPLEX);
  assign rec_state      = state_q;
  assign fault_src      = rec_src_q;

  AST_HALT_OUTS_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halt_cpu_a |=> (!out_en && halt_cpu_b)); // R9

endmodule

// File: tb/dual_lockstep_guard_tb_top.sv
`timescale 1ns/1ps
module dual_lockstep_guard_tb_top;

  localparam int DW  = 8;
  localparam int NF  = 3;
  localparam int WW  = 4;
  localparam int TMO = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          a_valid, b_valid;
  logic [DW-1:0] a_data, b_data;
  logic [NF-1:0] blk_fault;
  logic          degrade_en;
  logic [WW-1:0] window_len;
  logic          rollback_ack, restart_ack;
  logic          rollback_req, restart_req, halt_cpu_a, halt_cpu_b, out_en, simplex_active;
  logic [2:0]    rec_state;
  logic [1:0]    fault_src;
  logic [NF-1:0] fault_flags;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_lockstep_guard #(.DATA_W(DW), .LANE_W(4), .NFLAG(NF), .WIN_W(WW), .ACK_TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_a_valid(a_valid), .cpu_a_data(a_data),
    .cpu_b_valid(b_valid), .cpu_b_data(b_data),
    .blk_fault(blk_fault), .degrade_en(degrade_en), .window_len(window_len),
    .rollback_ack(rollback_ack), .restart_ack(restart_ack),
    .rollback_req(rollback_req), .restart_req(restart_req),
    .halt_cpu_a(halt_cpu_a), .halt_cpu_b(halt_cpu_b), .out_en(out_en),
    .simplex_active(simplex_active), .rec_state(rec_state),
    .fault_src(fault_src), .fault_flags(fault_flags)
  );

  localparam int S_RUN = 0, S_RB = 1, S_RS = 2, S_WATCH = 3, S_SPX = 4, S_HALT = 5;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input int exp);
    check({req, " state"}, int'(rec_state), exp);
    check({req, " out_en"}, int'(out_en), (exp != S_HALT) ? 1 : 0);
    check({req, " halt_a"}, int'(halt_cpu_a), (exp == S_HALT) ? 1 : 0);
    check({req, " halt_b"}, int'(halt_cpu_b), (exp == S_HALT || exp == S_SPX) ? 1 : 0);
    check({req, " simplex"}, int'(simplex_active), (exp == S_SPX) ? 1 : 0);
    check({req, " rb_req"}, int'(rollback_req), (exp == S_RB) ? 1 : 0);
    check({req, " rs_req"}, int'(restart_req), (exp == S_RS) ? 1 : 0);
  endtask

  task automatic set_idle();
    a_valid   = 1'b1;
    b_valid   = 1'b1;
    a_data    = DW'(cyc * 37 + 5);
    b_data    = a_data;
    blk_fault = '0;
  endtask

  // kind: 1 data mismatch, 2 strobe skew, 3 external flag
  task automatic set_fault(input int kind);
    set_idle();
    case (kind)
      1: b_data = a_data ^ 8'h10;
      2: b_valid = 1'b0;
      default: blk_fault = 3'b010;
    endcase
  endtask

  function automatic int exp_flags(input int kind);
    return (kind == 3) ? 2 : 0;
  endfunction

  task automatic pulse(input int kind);
    set_fault(kind);
    @(negedge clk);
    set_idle();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n        = 1'b0;
    rollback_ack = 1'b0;
    restart_ack  = 1'b0;
    set_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Fault presented d cycles after the rollback acknowledge cycle.
  task automatic window_case(input int w, input int d, input int mode, input int kind);
    int exp_st;
    string tag;
    degrade_en = mode[0];
    window_len = WW'(w);
    do_reset();
    pulse(1);
    check_state("R6 first fault", S_RB);
    for (int s = 0; s <= d; s++) begin
      rollback_ack = (s == 0);
      if (s == d) set_fault(kind);
      else set_idle();
      @(negedge clk);
    end
    rollback_ack = 1'b0;
    set_idle();
    @(negedge clk);
    if (d < w) begin
      exp_st = mode ? S_SPX : S_HALT;
      tag = mode ? "R10 repeat degrade" : "R8 repeat stop";
    end else begin
      exp_st = S_RB;
      tag = "R12 after window";
    end
    check_state(tag, exp_st);
    check({tag, " src"}, int'(fault_src), kind);
    check({tag, " flags"}, int'(fault_flags), exp_flags(kind));
  endtask

  initial begin
    degrade_en = 1'b0;
    window_len = WW'(3);
    do_reset();

    // R1 reset state
    check_state("R1 reset", S_RUN);
    check("R1 src", int'(fault_src), 0);
    check("R1 flags", int'(fault_flags), 0);

    // R2 no fault for equal data or both strobes low
    repeat (10) begin
      set_idle();
      @(negedge clk);
    end
    for (int i = 0; i < 16; i++) begin
      a_valid = 1'b0;
      b_valid = 1'b0;
      a_data  = DW'(i);
      b_data  = DW'(~i);
      @(negedge clk);
    end
    set_idle();
    @(negedge clk);
    @(negedge clk);
    check_state("R2 no fault", S_RUN);

    // R2 R3 R4 each source from RUN
    for (int k = 1; k <= 3; k++) begin
      do_reset();
      pulse(k);
      check_state("R6 source entry", S_RB);
      check((k == 1) ? "R2 src" : (k == 2) ? "R3 src" : "R4 src", int'(fault_src), k);
      check("R4 flags", int'(fault_flags), exp_flags(k));
    end

    // R5 priority
    do_reset();
    set_fault(1);
    blk_fault = 3'b101;
    @(negedge clk);
    set_idle();
    @(negedge clk);
    check("R5 ext over data", int'(fault_src), 3);
    check("R5 flags", int'(fault_flags), 5);
    do_reset();
    set_fault(2);
    blk_fault = 3'b001;
    @(negedge clk);
    set_idle();
    @(negedge clk);
    check("R5 ext over skew", int'(fault_src), 3);

    // R13 then R6 R7 timeout into restart
    do_reset();
    window_len = WW'(3);
    degrade_en = 1'b0;
    pulse(1);
    check_state("R6 rollback", S_RB);
    pulse(3);
    check_state("R13 ignored in rollback", S_RB);
    check("R13 src", int'(fault_src), 1);
    check("R13 flags", int'(fault_flags), 0);
    @(negedge clk);
    check_state("R7 still rollback", S_RB);
    @(negedge clk);
    check_state("R7 restart after timeout", S_RS);
    pulse(2);
    check_state("R13 ignored in restart", S_RS);
    check("R13 src restart", int'(fault_src), 1);
    restart_ack = 1'b1;
    @(negedge clk);
    restart_ack = 1'b0;
    check_state("R7 restart ack", S_WATCH);
    pulse(2);
    check_state("R8 repeat after restart", S_HALT);
    check("R8 src", int'(fault_src), 2);

    // R9 halt sticky
    for (int i = 0; i < 12; i++) begin
      rollback_ack = i[0];
      restart_ack  = i[1];
      degrade_en   = i[2];
      if (i % 3 == 0) set_fault(1 + i % 3);
      else set_idle();
      @(negedge clk);
    end
    rollback_ack = 1'b0;
    restart_ack  = 1'b0;
    set_idle();
    @(negedge clk);
    check_state("R9 halt sticky", S_HALT);
    do_reset();
    check_state("R9 reset clears halt", S_RUN);

    // R10 R11 simplex masking
    degrade_en = 1'b1;
    window_len = WW'(4);
    pulse(1);
    rollback_ack = 1'b1;
    @(negedge clk);
    rollback_ack = 1'b0;
    pulse(1);
    check_state("R10 degrade", S_SPX);
    pulse(1);
    pulse(2);
    repeat (3) @(negedge clk);
    check_state("R11 compare masked", S_SPX);
    check("R11 src kept", int'(fault_src), 1);
    pulse(3);
    check_state("R11 ext halts", S_HALT);
    check("R11 src ext", int'(fault_src), 3);

    // Window sweep: R8 R10 R12
    for (int w = 0; w <= 4; w++)
      for (int d = 0; d <= 5; d++)
        for (int m = 0; m <= 1; m++)
          for (int k = 1; k <= 3; k++)
            window_case(w, d, m, k);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule